// File: doc/BRIEF.md
# USB Device Endpoint Prime and Setup Status Registers

This block holds two software-visible registers for the device side of a USB controller. The first carries one transmit prime bit and one receive prime bit for each of six endpoints. Software sets a bit to ask the queue engine to fetch a new transfer descriptor for that endpoint and direction. The engine clears the bit once priming succeeds. The engine may also set a bit briefly while it re-primes after retiring a descriptor. The second register carries one flag for each endpoint. A flag is raised when a setup packet arrives on that endpoint, and software acknowledges it by writing a one.

Software reaches both registers through a plain memory-mapped bus. The bus has a single-cycle write strobe and a combinational read path. The queue engine sees the current prime bits and setup flags on dedicated output vectors, and it drives done, re-prime and setup-arrival pulses back in. The whole block works only in device mode. While the controller is in host mode, software writes and engine set pulses are ignored, and every readback and output vector shows zeros. The stored state is kept, so it reappears when the controller returns to device mode.

Top module: `ep_prime_regs`

## Requirements
- R1: The prime register decodes at byte offset 0x1B0. Endpoint n's transmit prime bit is at bit 16+n and its receive prime bit is at bit n, for n from 0 to 5. All other bits, and every unmapped offset, read as zero.
- R2: In device mode, a bus write of one to a prime bit sets it from the next cycle on. The new value shows on tx_prime_req/rx_prime_req and on readback. Writing zero to a prime bit leaves it unchanged.
- R3: A one on tx_prime_done[n] or rx_prime_done[n] clears the matching prime bit from the next cycle on.
- R4: In device mode, a one on tx_reprime[n] or rx_reprime[n] sets the matching prime bit from the next cycle on.
- R5: When a clear from a done pulse and a set (software write-one or re-prime) reach the same prime bit in the same cycle, the bit is set afterwards.
- R6: The setup status register decodes at byte offset 0x1AC, with endpoint n's flag at bit n. In device mode, a one on setup_rcvd[n] sets flag n from the next cycle on.
- R7: A device-mode bus write of one to a setup flag clears it from the next cycle on. Writing zero leaves it unchanged.
- R8: When a setup arrival and a write-one-to-clear reach the same flag in the same cycle, the flag is set afterwards.
- R9: While dev_mode is low, bus writes, re-prime pulses and setup arrivals have no effect. bus_rdata, tx_prime_req, rx_prime_req and setup_pend are all zero. Stored bits reappear once dev_mode returns high.
- R10: An active-high synchronous reset clears every prime bit and setup flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_mode | input | 1 | High when the controller runs as a device |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational readback of the register at bus_addr |
| tx_prime_done | input | 6 | Engine reports transmit priming complete, per endpoint |
| rx_prime_done | input | 6 | Engine reports receive priming complete, per endpoint |
| tx_reprime | input | 6 | Engine sets the transmit prime bit during re-priming |
| rx_reprime | input | 6 | Engine sets the receive prime bit during re-priming |
| setup_rcvd | input | 6 | Setup packet arrived, per endpoint |
| tx_prime_req | output | 6 | Current transmit prime bits toward the engine |
| rx_prime_req | output | 6 | Current receive prime bits toward the engine |
| setup_pend | output | 6 | Current setup status flags |

## Verification
The main set/clear logic is driven by a sequence of patterns, each applied to a known state. Lone software sets, lone done clears and lone re-prime sets show which source each bit responds to. Writes of all zeros, which must change nothing, separate write-one semantics from plain register loads. Same-cycle collisions of a clear with a set, on both the prime and the setup side, show that the arbitration lets the set win. Directed steps then write all ones and check that only the defined bit positions come back. Toggling dev_mode around writes and pulses tells gating of visibility apart from loss of stored state.

// File: rtl/ep_regs_pkg.sv
package ep_regs_pkg;

    // Which register a bus offset selects
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PRIME = 2'd1,
        SEL_SETUP = 2'd2
    } reg_sel_e;

    // Bit position of endpoint 0's transmit prime bit in the prime register
    localparam int TX_LSB = 16;
    // Bit position of endpoint 0's receive prime bit and setup flag
    localparam int RX_LSB = 0;

endpackage

// File: rtl/ep_addr_decode.sv
module ep_addr_decode
    import ep_regs_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] PRIME_OFS = 12'h1B0,
    parameter logic [11:0] SETUP_OFS = 12'h1AC
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] PRIME_A = ADDR_W'(PRIME_OFS);
    localparam logic [ADDR_W-1:0] SETUP_A = ADDR_W'(SETUP_OFS);

    always_comb begin
        if (addr == PRIME_A) begin
            sel = SEL_PRIME;
        end else if (addr == SETUP_A) begin
            sel = SEL_SETUP;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/ep_prime_bank.sv
// One direction's prime bits: set by software or re-prime, cleared by the engine.
// A set in the same cycle as a clear wins.
module ep_prime_bank #(
    parameter int NUM_EP = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] sw_set,
    input  logic [NUM_EP-1:0] hw_set,
    input  logic [NUM_EP-1:0] hw_clr,
    output logic [NUM_EP-1:0] bits
);

    typedef struct packed {
        logic [NUM_EP-1:0] prime;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prime = (st_q.prime & ~hw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.prime;

endmodule

// File: rtl/ep_setup_bank.sv
// Setup flags: set by packet arrival, cleared by software write-one.
// Arrival in the same cycle as a clear wins.
module ep_setup_bank #(
    parameter int NUM_EP = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] hw_set,
    input  logic [NUM_EP-1:0] sw_clr,
    output logic [NUM_EP-1:0] flags
);

    typedef struct packed {
        logic [NUM_EP-1:0] seen;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = (st_q.seen & ~sw_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.seen;

endmodule

// File: rtl/ep_prime_regs.sv
module ep_prime_regs
    import ep_regs_pkg::*;
#(
    parameter int          NUM_EP    = 6,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter logic [11:0] PRIME_OFS = 12'h1B0,
    parameter logic [11:0] SETUP_OFS = 12'h1AC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_mode,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_EP-1:0] tx_prime_done,
    input  logic [NUM_EP-1:0] rx_prime_done,
    input  logic [NUM_EP-1:0] tx_reprime,
    input  logic [NUM_EP-1:0] rx_reprime,
    input  logic [NUM_EP-1:0] setup_rcvd,
    output logic [NUM_EP-1:0] tx_prime_req,
    output logic [NUM_EP-1:0] rx_prime_req,
    output logic [NUM_EP-1:0] setup_pend
);

    // Direction index: 0 = receive, 1 = transmit
    localparam int NDIR = 2;
    localparam logic [NUM_EP-1:0] NONE = '0;

    reg_sel_e sel;

    logic wr_prime, wr_setup;
    logic [NDIR-1:0][NUM_EP-1:0] dir_sw_set;
    logic [NDIR-1:0][NUM_EP-1:0] dir_hw_set;
    logic [NDIR-1:0][NUM_EP-1:0] dir_hw_clr;
    logic [NDIR-1:0][NUM_EP-1:0] dir_bits;
    logic [NUM_EP-1:0] su_set, su_clr, su_flags;
    logic unused_wdata;

    ep_addr_decode #(
        .ADDR_W   (ADDR_W),
        .PRIME_OFS(PRIME_OFS),
        .SETUP_OFS(SETUP_OFS)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    assign wr_prime = dev_mode && bus_wr && (sel == SEL_PRIME);
    assign wr_setup = dev_mode && bus_wr && (sel == SEL_SETUP);

    assign dir_hw_set[0] = dev_mode ? rx_reprime : NONE;
    assign dir_hw_set[1] = dev_mode ? tx_reprime : NONE;
    assign dir_hw_clr[0] = rx_prime_done;
    assign dir_hw_clr[1] = tx_prime_done;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam int LSB = (d == 0) ? RX_LSB : TX_LSB;

        assign dir_sw_set[d] = wr_prime ? bus_wdata[LSB +: NUM_EP] : NONE;

        ep_prime_bank #(
            .NUM_EP(NUM_EP)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .sw_set(dir_sw_set[d]),
            .hw_set(dir_hw_set[d]),
            .hw_clr(dir_hw_clr[d]),
            .bits  (dir_bits[d])
        );
    end

    assign su_set = dev_mode ? setup_rcvd : NONE;
    assign su_clr = wr_setup ? bus_wdata[RX_LSB +: NUM_EP] : NONE;

    ep_setup_bank #(
        .NUM_EP(NUM_EP)
    ) u_setup (
        .clk   (clk),
        .rst   (rst),
        .hw_set(su_set),
        .sw_clr(su_clr),
        .flags (su_flags)
    );

    // Readback and engine-facing vectors; all zero outside device mode
    always_comb begin
        bus_rdata = '0;
        if (dev_mode) begin
            case (sel)
                SEL_PRIME: begin
                    bus_rdata[TX_LSB +: NUM_EP] = dir_bits[1];
                    bus_rdata[RX_LSB +: NUM_EP] = dir_bits[0];
                end
                SEL_SETUP: begin
                    bus_rdata[RX_LSB +: NUM_EP] = su_flags;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign tx_prime_req = dev_mode ? dir_bits[1] : NONE;
    assign rx_prime_req = dev_mode ? dir_bits[0] : NONE;
    assign setup_pend   = dev_mode ? su_flags    : NONE;

    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/ep_prime_regs_chk.sv
module ep_prime_regs_chk #(
    parameter int          NUM_EP    = 6,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter logic [11:0] PRIME_OFS = 12'h1B0,
    parameter logic [11:0] SETUP_OFS = 12'h1AC
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_mode,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_EP-1:0] tx_prime_done,
    input logic [NUM_EP-1:0] rx_prime_done,
    input logic [NUM_EP-1:0] tx_reprime,
    input logic [NUM_EP-1:0] rx_reprime,
    input logic [NUM_EP-1:0] setup_rcvd,
    input logic [NUM_EP-1:0] tx_prime_req,
    input logic [NUM_EP-1:0] rx_prime_req,
    input logic [NUM_EP-1:0] setup_pend
);

    logic              at_prime, at_setup, sw_prime, sw_setup;
    logic [NUM_EP-1:0] tx_wr, rx_wr, tx_any_set, rx_any_set;
    logic [NUM_EP-1:0] tx_clear_only, rx_clear_only, su_clear_only;

    assign at_prime = (bus_addr == ADDR_W'(PRIME_OFS));
    assign at_setup = (bus_addr == ADDR_W'(SETUP_OFS));
    assign sw_prime = dev_mode && bus_wr && at_prime;
    assign sw_setup = dev_mode && bus_wr && at_setup;
    assign tx_wr    = bus_wdata[16 +: NUM_EP];
    assign rx_wr    = bus_wdata[0 +: NUM_EP];

    assign tx_any_set    = dev_mode ? ((sw_prime ? tx_wr : '0) | tx_reprime) : '0;
    assign rx_any_set    = dev_mode ? ((sw_prime ? rx_wr : '0) | rx_reprime) : '0;
    assign tx_clear_only = tx_prime_done & ~tx_any_set;
    assign rx_clear_only = rx_prime_done & ~rx_any_set;
    assign su_clear_only = (sw_setup ? rx_wr : '0) & ~(dev_mode ? setup_rcvd : '0);

    // R2: software write-one sets transmit and receive prime bits
    p_sw_set_r2: assert property (@(posedge clk) disable iff (rst)
        sw_prime |=> (!dev_mode ||
            (((tx_prime_req & $past(tx_wr)) == $past(tx_wr)) &&
             ((rx_prime_req & $past(rx_wr)) == $past(rx_wr)))));

    // R3: a done pulse with no competing set clears the bit
    p_done_clr_r3: assert property (@(posedge clk) disable iff (rst)
        ((tx_clear_only | rx_clear_only) != '0) |=>
            (((tx_prime_req & $past(tx_clear_only)) == '0) &&
             ((rx_prime_req & $past(rx_clear_only)) == '0)));

    // R4 and R5: re-prime sets the bit even against a done pulse
    p_reprime_r4: assert property (@(posedge clk) disable iff (rst)
        (dev_mode && ((tx_reprime | rx_reprime) != '0)) |=> (!dev_mode ||
            (((tx_prime_req & $past(tx_reprime)) == $past(tx_reprime)) &&
             ((rx_prime_req & $past(rx_reprime)) == $past(rx_reprime)))));

    // R6 and R8: setup arrival sets the flag even against a clear
    p_setup_set_r6: assert property (@(posedge clk) disable iff (rst)
        (dev_mode && (setup_rcvd != '0)) |=>
            (!dev_mode || ((setup_pend & $past(setup_rcvd)) == $past(setup_rcvd))));

    // R7: write-one clears setup flags
    p_setup_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (su_clear_only != '0) |=> ((setup_pend & $past(su_clear_only)) == '0));

    // R9: nothing visible outside device mode
    p_host_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !dev_mode |-> (bus_rdata == '0 && tx_prime_req == '0 &&
                       rx_prime_req == '0 && setup_pend == '0));

    // R10: reset empties every bit
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (tx_prime_req == '0 && rx_prime_req == '0 && setup_pend == '0));

endmodule

bind ep_prime_regs ep_prime_regs_chk #(
    .NUM_EP   (NUM_EP),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PRIME_OFS(PRIME_OFS),
    .SETUP_OFS(SETUP_OFS)
) u_chk (.*);

// File: tb/sim_ep_prime_regs.sv
module sim_ep_prime_regs;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_PRIME = 12'h1B0;
    localparam logic [11:0] A_SETUP = 12'h1AC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_mode = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  tx_prime_done = '0, rx_prime_done = '0;
    logic [5:0]  tx_reprime = '0, rx_reprime = '0, setup_rcvd = '0;
    logic [5:0]  tx_prime_req, rx_prime_req, setup_pend;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_prime_regs u0 (
        .clk(clk), .rst(rst), .dev_mode(dev_mode),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .tx_prime_done(tx_prime_done), .rx_prime_done(rx_prime_done),
        .tx_reprime(tx_reprime), .rx_reprime(rx_reprime),
        .setup_rcvd(setup_rcvd),
        .tx_prime_req(tx_prime_req), .rx_prime_req(rx_prime_req),
        .setup_pend(setup_pend)
    );

    // op: 0 engine pulses only, 1 write prime register, 2 write setup register
    // For op 2 the wrx field carries the setup write data.
    typedef struct packed {
        logic [1:0] op;
        logic [5:0] wtx, wrx, dtx, drx, rtx, rrx, su, etx, erx, esu;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 6'h01, 6'h02, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h01, 6'h02, 6'h00}, // R2
        '{2'd1, 6'h20, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h21, 6'h02, 6'h00}, // R2 endpoint 5
        '{2'd0, 6'h00, 6'h00, 6'h01, 6'h00, 6'h00, 6'h00, 6'h00, 6'h20, 6'h02, 6'h00}, // R3
        '{2'd0, 6'h00, 6'h00, 6'h20, 6'h02, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00}, // R3
        '{2'd0, 6'h00, 6'h00, 6'h00, 6'h00, 6'h04, 6'h08, 6'h00, 6'h04, 6'h08, 6'h00}, // R4
        '{2'd1, 6'h10, 6'h00, 6'h04, 6'h00, 6'h00, 6'h00, 6'h00, 6'h10, 6'h08, 6'h00}, // R2 with R3
        '{2'd1, 6'h00, 6'h08, 6'h00, 6'h08, 6'h00, 6'h00, 6'h00, 6'h10, 6'h08, 6'h00}, // R5
        '{2'd0, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h05, 6'h10, 6'h08, 6'h05}, // R6
        '{2'd2, 6'h00, 6'h01, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h10, 6'h08, 6'h04}, // R7
        '{2'd2, 6'h00, 6'h04, 6'h00, 6'h00, 6'h00, 6'h00, 6'h04, 6'h10, 6'h08, 6'h04}, // R8
        '{2'd2, 6'h00, 6'h3F, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h10, 6'h08, 6'h00}, // R7
        '{2'd1, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h10, 6'h08, 6'h00}, // R2 zeros
        '{2'd0, 6'h00, 6'h00, 6'h10, 6'h08, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] td, rd_, tr, rr, su);
        @(negedge clk);
        tx_prime_done = td; rx_prime_done = rd_;
        tx_reprime = tr; rx_reprime = rr; setup_rcvd = su;
        @(negedge clk);
        tx_prime_done = '0; rx_prime_done = '0;
        tx_reprime = '0; rx_reprime = '0; setup_rcvd = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;

        // R10: reset state
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd(A_PRIME, d);
        check("R10 prime after reset", d, 32'h0);
        rd(A_SETUP, d);
        check("R10 setup after reset", d, 32'h0);
        check("R10 outputs after reset", {14'h0, tx_prime_req, rx_prime_req, setup_pend}, 32'h0);

        // Vector walk: inputs held for one edge, outputs sampled at the next falling edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr        = (VECS[i].op != 2'd0);
            bus_addr      = (VECS[i].op == 2'd2) ? A_SETUP : A_PRIME;
            bus_wdata     = (VECS[i].op == 2'd2) ? {26'h0, VECS[i].wrx}
                                                 : {10'h0, VECS[i].wtx, 10'h0, VECS[i].wrx};
            tx_prime_done = VECS[i].dtx;
            rx_prime_done = VECS[i].drx;
            tx_reprime    = VECS[i].rtx;
            rx_reprime    = VECS[i].rrx;
            setup_rcvd    = VECS[i].su;
            @(negedge clk);
            bus_wr = 1'b0; bus_wdata = '0;
            tx_prime_done = '0; rx_prime_done = '0;
            tx_reprime = '0; rx_reprime = '0; setup_rcvd = '0;
            check($sformatf("R2/R8 vector %0d", i),
                  {14'h0, tx_prime_req, rx_prime_req, setup_pend},
                  {14'h0, VECS[i].etx, VECS[i].erx, VECS[i].esu});
        end

        // R1: bit positions and reserved bits
        wr(A_PRIME, 32'hFFFF_FFFF);
        rd(A_PRIME, d);
        check("R1 prime readback layout", d, 32'h003F_003F);
        check("R1 tx_prime_req all", {26'h0, tx_prime_req}, 32'h3F);
        rd(12'h1B4, d);
        check("R1 unmapped offset", d, 32'h0);

        // R3: all done pulses empty the register
        pulse(6'h3F, 6'h3F, 6'h00, 6'h00, 6'h00);
        rd(A_PRIME, d);
        check("R3 all cleared", d, 32'h0);

        // R6: setup flags at bits 5:0
        pulse(6'h00, 6'h00, 6'h00, 6'h00, 6'h2A);
        rd(A_SETUP, d);
        check("R6 setup readback", d, 32'h0000_002A);

        // R7: writing zeros to the setup register changes nothing
        wr(A_SETUP, 32'h0);
        rd(A_SETUP, d);
        check("R7 zero write ignored", d, 32'h0000_002A);

        // R9: host mode gating
        wr(A_PRIME, 32'h0001_0000);
        @(negedge clk);
        dev_mode = 1'b0;
        rd(A_PRIME, d);
        check("R9 host prime readback", d, 32'h0);
        rd(A_SETUP, d);
        check("R9 host setup readback", d, 32'h0);
        check("R9 host outputs", {14'h0, tx_prime_req, rx_prime_req, setup_pend}, 32'h0);
        wr(A_PRIME, 32'h0020_0020);
        wr(A_SETUP, 32'h0000_003F);
        pulse(6'h00, 6'h00, 6'h02, 6'h04, 6'h01);
        @(negedge clk);
        dev_mode = 1'b1;
        rd(A_PRIME, d);
        check("R9 prime kept, host writes ignored", d, 32'h0001_0000);
        rd(A_SETUP, d);
        check("R9 setup kept, host events ignored", d, 32'h0000_002A);

        // R10: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(A_PRIME, d);
        check("R10 prime after second reset", d, 32'h0);
        rd(A_SETUP, d);
        check("R10 setup after second reset", d, 32'h0);

        summary();
    end

endmodule